// File: doc/BRIEF.md
# Banked Level Interrupt Aggregator

This block collects 72 level-sensitive interrupt lines into three banks and drives a single interrupt request to a processor. The root bank carries 8 local lines. Two peripheral banks, A and B, carry 32 lines each. Every bank has a mask. Software turns mask bits on by writing ones to a set register and turns them off by writing ones to a clear register. A pending register shows the lines that are both asserted and unmasked.

The root pending word summarises the whole controller. A handler reads it first. Its low eight bits are the local lines. One summary bit per peripheral bank says that some ordinary line in that bank is pending. A fixed subset of peripheral lines, the fast-path lines, get a bit of their own in the root word. These lines let a handler identify the source with one read. A pending fast-path line appears in its own bank's pending word and in its root-word bit. It does not raise its bank's summary bit. Fast-path lines are masked only through their own bank's mask. The root mask covers the local lines and nothing else.

The register port is a simple single-cycle interface with a 0x200-byte window. Reads are combinational. Writes take effect at the clock edge.

Top module: `irq_tree_ctrl`

## Requirements
- R1: After reset, every mask is 0. Every pending and mask read returns 0, even with all lines asserted, and `irq_out` is 0.
- R2: A write to a set register (A at 0x10, B at 0x14, root at 0x18) ORs the written ones into that bank's mask. Zero bits leave the mask unchanged. The mask reads back at both its set offset and its clear offset.
- R3: A write to a clear register (A at 0x1C, B at 0x20, root at 0x24) clears the mask bits written as one. Zero bits leave the mask unchanged.
- R4: The bank A pending word (0x04) and the bank B pending word (0x08) equal the line levels ANDed with the bank's mask. Bit n of each word is line n.
- R5: Root pending word (0x00) bits 7..0 equal the local lines ANDed with root mask bits 7..0.
- R6: Root bit 8 is 1 exactly when some unmasked, asserted bank A line outside the fast-path set is present. Root bit 9 follows the same rule for bank B. Fast-path lines never raise these bits.
- R7: Bank A lines 7, 9, 10, 18 and 19 drive root bits 10, 11, 12, 13 and 14 in that order. Bank B lines 21, 22, 23, 24, 25 and 30 drive root bits 15 to 20 in that order. Each of these bits is the line's own masked pending bit, which also shows in its bank word.
- R8: Root mask bits 31..8 always read 0. Writing them through the root set or clear register has no effect on any pending bit, including the fast-path bits.
- R9: Root pending bits 31..21 always read 0.
- R10: `irq_out` equals the OR of all root pending bits, delayed by one clock.
- R11: Reads of unmapped or non-word-aligned addresses return 0. Writes to them change no mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W (9) | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| src_root | input | 8 | Local interrupt lines, level-sensitive |
| src_a | input | 32 | Bank A interrupt lines, level-sensitive |
| src_b | input | 32 | Bank B interrupt lines, level-sensitive |
| irq_out | output | 1 | Registered interrupt request |

## Verification
A corrupted mask bit shows up at once in the pending word of its bank. It also shows in the root summary or fast-path bit that the line feeds, and one clock later in `irq_out`. A fast-path line that is wired wrongly, or that leaks into a summary bit, is exposed by driving each line of every bank on its own and comparing the whole root word. Mask-write faults are caught by reading the mask back after each set or clear write, and by long runs of pseudo-random masks and line patterns.

// File: rtl/irq_tree_pkg.sv
package irq_tree_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LOCAL_N   = 8;
  localparam int unsigned BANKS     = 3;
  localparam int unsigned FAST_A_N  = 5;
  localparam int unsigned FAST_B_N  = 6;
  localparam int unsigned SUM_A_POS = 8;
  localparam int unsigned SUM_B_POS = 9;
  localparam int unsigned FAST_A_LO = 10;
  localparam int unsigned FAST_B_LO = FAST_A_LO + FAST_A_N;

  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_PEND = 2'd1,
    RK_SET  = 2'd2,
    RK_CLR  = 2'd3
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  // Bank A line routed to fast-path slot k (slot order is the root bit order).
  function automatic int unsigned fast_a_line(int unsigned k);
    case (k)
      0: return 7;
      1: return 9;
      2: return 10;
      3: return 18;
      default: return 19;
    endcase
  endfunction

  function automatic int unsigned fast_b_line(int unsigned k);
    case (k)
      0: return 21;
      1: return 22;
      2: return 23;
      3: return 24;
      4: return 25;
      default: return 30;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] fast_a_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < FAST_A_N; k++) m[fast_a_line(k)] = 1'b1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] fast_b_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < FAST_B_N; k++) m[fast_b_line(k)] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] FAST_A_MASK = fast_a_mask();
  localparam logic [WORD_W-1:0] FAST_B_MASK = fast_b_mask();
  localparam logic [WORD_W-1:0] ROOT_WMASK  =
    {{(WORD_W-LOCAL_N){1'b0}}, {LOCAL_N{1'b1}}};

  // Word index (byte offset / 4) to register selection. Bank codes: 0 root, 1 A, 2 B.
  function automatic reg_sel_t decode_word(int unsigned idx);
    reg_sel_t s;
    s.kind = RK_NONE;
    s.bank = 2'd0;
    case (idx)
      0: begin s.kind = RK_PEND; s.bank = 2'd0; end
      1: begin s.kind = RK_PEND; s.bank = 2'd1; end
      2: begin s.kind = RK_PEND; s.bank = 2'd2; end
      4: begin s.kind = RK_SET;  s.bank = 2'd1; end
      5: begin s.kind = RK_SET;  s.bank = 2'd2; end
      6: begin s.kind = RK_SET;  s.bank = 2'd0; end
      7: begin s.kind = RK_CLR;  s.bank = 2'd1; end
      8: begin s.kind = RK_CLR;  s.bank = 2'd2; end
      9: begin s.kind = RK_CLR;  s.bank = 2'd0; end
      default: ;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned   W        = 32,
  parameter logic [W-1:0]  WRITABLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;
  logic         mask_ce;
  logic [W-1:0] hit;

  always_comb begin
    hit     = wdata & WRITABLE;
    mask_ce = set_stb | clr_stb;
    mask_d  = mask_q;
    if (set_stb) mask_d = mask_d | hit;
    if (clr_stb) mask_d = mask_d & ~hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_ce) begin
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/irq_root_word.sv
module irq_root_word
  import irq_tree_pkg::*;
(
  input  logic [LOCAL_N-1:0] root_lvl,
  input  logic [WORD_W-1:0]  pend_a,
  input  logic [WORD_W-1:0]  pend_b,
  output logic [WORD_W-1:0]  root_word
);

  always_comb begin
    root_word                = '0;
    root_word[LOCAL_N-1:0]   = root_lvl;
    root_word[SUM_A_POS]     = |(pend_a & ~FAST_A_MASK);
    root_word[SUM_B_POS]     = |(pend_b & ~FAST_B_MASK);
    for (int unsigned k = 0; k < FAST_A_N; k++)
      root_word[FAST_A_LO + k] = pend_a[fast_a_line(k)];
    for (int unsigned k = 0; k < FAST_B_N; k++)
      root_word[FAST_B_LO + k] = pend_b[fast_b_line(k)];
  end

endmodule

// File: rtl/irq_tree_ctrl.sv
module irq_tree_ctrl
  import irq_tree_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  input  logic [LOCAL_N-1:0]  src_root,
  input  logic [WORD_W-1:0]   src_a,
  input  logic [WORD_W-1:0]   src_b,
  output logic                irq_out
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // Address decode
  reg_sel_t          sel;
  logic [IDX_W-1:0]  word_idx;

  assign word_idx = bus_addr[ADDR_W-1:2];

  always_comb begin
    if (bus_addr[1:0] == 2'b00) sel = decode_word(int'(word_idx));
    else                        sel = '{kind: RK_NONE, bank: 2'd0};
  end

  // Mask registers, one per bank
  logic [WORD_W-1:0] en_q [BANKS];
  logic [BANKS-1:0]  set_stb;
  logic [BANKS-1:0]  clr_stb;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign set_stb[b] = bus_wr && (sel.kind == RK_SET) && (sel.bank == 2'(b));
    assign clr_stb[b] = bus_wr && (sel.kind == RK_CLR) && (sel.bank == 2'(b));

    irq_mask_reg #(
      .W        (WORD_W),
      .WRITABLE ((b == 0) ? ROOT_WMASK : {WORD_W{1'b1}})
    ) u_mask (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .set_stb (set_stb[b]),
      .clr_stb (clr_stb[b]),
      .wdata   (bus_wdata),
      .mask_q  (en_q[b])
    );
  end

  // Pending words
  logic [WORD_W-1:0]  pend_a;
  logic [WORD_W-1:0]  pend_b;
  logic [LOCAL_N-1:0] root_lvl;
  logic [WORD_W-1:0]  root_word;

  assign pend_a   = src_a & en_q[1];
  assign pend_b   = src_b & en_q[2];
  assign root_lvl = src_root & en_q[0][LOCAL_N-1:0];

  irq_root_word u_root (
    .root_lvl  (root_lvl),
    .pend_a    (pend_a),
    .pend_b    (pend_b),
    .root_word (root_word)
  );

  // Read mux
  always_comb begin
    bus_rdata = '0;
    case (sel.kind)
      RK_PEND: begin
        case (sel.bank)
          2'd0:    bus_rdata = root_word;
          2'd1:    bus_rdata = pend_a;
          2'd2:    bus_rdata = pend_b;
          default: bus_rdata = '0;
        endcase
      end
      RK_SET, RK_CLR: begin
        case (sel.bank)
          2'd0:    bus_rdata = en_q[0];
          2'd1:    bus_rdata = en_q[1];
          2'd2:    bus_rdata = en_q[2];
          default: bus_rdata = '0;
        endcase
      end
      default: bus_rdata = '0;
    endcase
  end

  // Interrupt request register
  logic irq_d;
  logic irq_q;

  assign irq_d = |root_word;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) irq_q <= 1'b0;
    else            irq_q <= irq_d;
  end

  assign irq_out = irq_q;

endmodule

// File: rtl/irq_tree_chk.sv
module irq_tree_chk
  import irq_tree_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] en_a,
  input logic [WORD_W-1:0] en_root,
  input logic [WORD_W-1:0] src_a,
  input logic [WORD_W-1:0] root_word,
  input logic              irq_out
);

  localparam logic [ADDR_W-1:0] ADR_SET_A = ADDR_W'(9'h010);
  localparam logic [ADDR_W-1:0] ADR_CLR_A = ADDR_W'(9'h01C);

  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_SET_A) |=> ((en_a & $past(bus_wdata)) == $past(bus_wdata)));

  a_r3_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_CLR_A) |=> ((en_a & $past(bus_wdata)) == '0));

  a_r8_root_mask_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    en_root[WORD_W-1:LOCAL_N] == '0);

  a_r7_fast_a_source: assert property (@(posedge clk) disable iff (!rst_n)
    (root_word[FAST_B_LO-1:FAST_A_LO] != '0) |-> ((src_a & en_a & FAST_A_MASK) != '0));

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    root_word[WORD_W-1:FAST_B_LO+FAST_B_N] == '0);

  a_r10_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|root_word));

endmodule

bind irq_tree_ctrl irq_tree_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .en_a      (en_q[1]),
  .en_root   (en_q[0]),
  .src_a     (src_a),
  .root_word (root_word),
  .irq_out   (irq_out)
);

// File: tb/sim_irq_tree_ctrl.sv
`timescale 1ns/1ps
module sim_irq_tree_ctrl;

  localparam int WD_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [7:0]  src_root;
  logic [31:0] src_a;
  logic [31:0] src_b;
  logic        irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m0, m1, m2;

  always #2.5 clk = ~clk;

  irq_tree_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_root(src_root),
    .src_a(src_a), .src_b(src_b), .irq_out(irq_out)
  );

  function automatic int a_line(int k);
    int t[5] = '{7, 9, 10, 18, 19};
    return t[k];
  endfunction

  function automatic int b_line(int k);
    int t[6] = '{21, 22, 23, 24, 25, 30};
    return t[k];
  endfunction

  function automatic logic [31:0] exp_root(logic [7:0] s0, logic [31:0] sa, logic [31:0] sb,
                                           logic [31:0] e0, logic [31:0] ea, logic [31:0] eb);
    logic [31:0] w, pa, pb, fa, fb;
    pa = sa & ea;
    pb = sb & eb;
    fa = 0;
    fb = 0;
    for (int k = 0; k < 5; k++) fa[a_line(k)] = 1'b1;
    for (int k = 0; k < 6; k++) fb[b_line(k)] = 1'b1;
    w = 0;
    w[7:0] = s0 & e0[7:0];
    w[8] = |(pa & ~fa);
    w[9] = |(pb & ~fb);
    for (int k = 0; k < 5; k++) w[10 + k] = pa[a_line(k)];
    for (int k = 0; k < 6; k++) w[15 + k] = pb[b_line(k)];
    return w;
  endfunction

  function automatic logic [31:0] xs(logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_masks(input logic [31:0] e0, input logic [31:0] ea, input logic [31:0] eb);
    wr(9'h024, 32'hFFFF_FFFF); wr(9'h018, e0);
    wr(9'h01C, 32'hFFFF_FFFF); wr(9'h010, ea);
    wr(9'h020, 32'hFFFF_FFFF); wr(9'h014, eb);
    m0 = e0 & 32'hFF; m1 = ea; m2 = eb;
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d, er;
    er = exp_root(src_root, src_a, src_b, m0, m1, m2);
    rd(9'h000, d); chk({tag, " R6 R7 R9 root"}, d, er);
    rd(9'h004, d); chk({tag, " R4 bankA"}, d, src_a & m1);
    rd(9'h008, d); chk({tag, " R4 bankB"}, d, src_b & m2);
    chk({tag, " R10 irq"}, {31'b0, irq_out}, {31'b0, |er});
  endtask

  initial begin
    #(WD_CYCLES * 5.0);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r, er;
    rst_n = 1'b0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    src_root = 8'hFF; src_a = '1; src_b = '1;
    m0 = 0; m1 = 0; m2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state with every line asserted
    for (int a = 0; a < 10; a++) begin
      rd(9'(a * 4), d); chk("R1 reset read", d, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq_out}, 32'h0);
    src_root = 0; src_a = 0; src_b = 0;

    // R2: set semantics and readback at both offsets
    wr(9'h010, 32'hA5A5_0F0F);
    rd(9'h010, d); chk("R2 set A", d, 32'hA5A5_0F0F);
    rd(9'h01C, d); chk("R2 readback at clear A", d, 32'hA5A5_0F0F);
    wr(9'h010, 32'h0);
    rd(9'h010, d); chk("R2 zero write keeps", d, 32'hA5A5_0F0F);
    wr(9'h014, 32'h0000_0001); wr(9'h014, 32'h8000_0000);
    rd(9'h014, d); chk("R2 set B accumulates", d, 32'h8000_0001);

    // R3: clear semantics
    wr(9'h01C, 32'h0000_0F00);
    rd(9'h010, d); chk("R3 clear A", d, 32'hA5A5_000F);
    wr(9'h020, 32'h0);
    rd(9'h014, d); chk("R3 zero clear keeps", d, 32'h8000_0001);
    wr(9'h020, 32'h8000_0000);
    rd(9'h020, d); chk("R3 clear B", d, 32'h0000_0001);

    // R11: unmapped and misaligned accesses
    wr(9'h00C, 32'hFFFF_FFFF); wr(9'h028, 32'hFFFF_FFFF); wr(9'h011, 32'hFFFF_FFFF);
    rd(9'h010, d); chk("R11 A mask untouched", d, 32'hA5A5_000F);
    rd(9'h014, d); chk("R11 B mask untouched", d, 32'h0000_0001);
    rd(9'h018, d); chk("R11 root mask untouched", d, 32'h0);
    rd(9'h00C, d); chk("R11 read 0x0C", d, 32'h0);
    rd(9'h1FC, d); chk("R11 read 0x1FC", d, 32'h0);
    src_a = '1;
    rd(9'h005, d); chk("R11 misaligned read", d, 32'h0);
    src_a = 0;

    // R8: root mask only covers the local lines
    set_masks(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    wr(9'h018, 32'hFFFF_FFFF); m0 = 32'hFF;
    rd(9'h018, d); chk("R8 root mask width", d, 32'h0000_00FF);
    @(negedge clk); src_a = 32'h0000_0080;
    wr(9'h024, 32'h001F_FF00);
    rd(9'h000, d); chk("R8 fast bit survives root clear", d, 32'h0000_0400);
    rd(9'h024, d); chk("R8 root mask after clear", d, 32'h0000_00FF);
    @(negedge clk); src_a = 32'h0000_0001;
    rd(9'h000, d); chk("R8 summary survives root clear", d, 32'h0000_0100);
    @(negedge clk); src_a = 0;

    // R5/R6/R7/R10: single-line sweeps with everything unmasked
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); src_root = 8'(1 << i);
      check_all("R5 sweep local");
    end
    @(negedge clk); src_root = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); src_a = 32'(1) << i;
      check_all("R6 R7 sweep A");
    end
    @(negedge clk); src_a = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); src_b = 32'(1) << i;
      check_all("R6 R7 sweep B");
    end

    // R10: registered request, one clock late
    @(negedge clk); src_b = 0;
    @(negedge clk);
    chk("R10 idle irq", {31'b0, irq_out}, 32'h0);
    @(negedge clk); src_root = 8'h01; #1;
    chk("R10 irq not yet", {31'b0, irq_out}, 32'h0);
    @(negedge clk);
    chk("R10 irq one clock later", {31'b0, irq_out}, 32'h1);
    @(negedge clk); src_root = 0;

    // R4/R6/R7 masking: a masked fast-path line shows nowhere
    set_masks(32'hFF, 32'hFFFF_FF7F, 32'hBFFF_FFFF);
    @(negedge clk); src_a = 32'h0000_0080; src_b = 32'h4000_0000;
    check_all("R7 masked fast lines");

    // Pseudo-random masks and line patterns
    r = 32'h1234_5678;
    for (int it = 0; it < 120; it++) begin
      logic [31:0] e0, ea, eb;
      r = xs(r); e0 = r;
      r = xs(r); ea = r;
      r = xs(r); eb = r;
      set_masks(e0, ea, eb);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        r = xs(r); src_a = r;
        r = xs(r); src_b = r & xs(r);
        r = xs(r); src_root = r[7:0];
        check_all("R4 R5 R6 R7 R10 random");
      end
    end

    er = 0;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule